// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block is the controller-side engine that brings a DDR2 memory device from power-on to a usable state. A single start pulse launches a fixed, timed program. Clock enable and termination are held low while the memory clock settles. Clock enable is then raised. After that the block issues precharge-all commands, the four mode register writes in their required order (one of them resets the DLL), a burst of auto-refresh commands, the normal-operation mode write, and the pair of drive-impedance writes (default, then exit). Every cycle that carries no command drives an explicit NOP, so the device never sees an undefined command.

All waits are counted in clocks. They are derived at elaboration from the clock period and from the interval lengths given in picoseconds. CAS latency, write recovery, additive latency, burst length, burst type and power-down exit mode are parameters that are packed into the mode words. When the program finishes, a ready flag rises and stays high until the next start.

Top module: `ddr2_init_seq`

## Requirements
- R1: After start is sampled, cke_o and odt_o stay 0 and NOP is driven for STABLE_CK = ceil(T_STABLE_PS / CLK_PERIOD_PS) clocks (25000 at the defaults). cke_o rises exactly STABLE_CK clocks after the edge that sampled start. odt_o is 0 at all times.
- R2: The command is the tuple {cs_no, ras_no, cas_no, we_no}. NOP = 0111, precharge-all = 0010, mode write = 0000, refresh = 0001. Every cycle without a command carries NOP, with ba_o and addr_o at 0.
- R3: The commands come in this order: precharge-all; mode write BA=2 with address 0; mode write BA=3 with address 0; mode write BA=1 with A0=0 (DLL on) and the additive latency in A5..A3; main mode write (BA=0) with A8=1; precharge-all; N_REF refreshes; main mode write with A8=0; BA=1 write with A9..A7=111; BA=1 write with A9..A7=000. In the BA=1 writes, all bits other than A5..A3 and A9..A7 are 0.
- R4: The main mode word holds the burst length code in A2..A0 (4 gives 010, 8 gives 011), the burst type in A3, the CAS latency in A6..A4, 0 in A7, the DLL reset in A8, the write recovery minus one in A11..A9, the power-down exit mode in A12, and 0 in A13.
- R5: The first precharge-all is issued CKE_CK = ceil(T_CKE_PS / CLK_PERIOD_PS) clocks (50) after cke_o rises.
- R6: The next command follows RP_CK clocks (2) after a precharge-all, MRD_CK clocks (2) after a mode write, and RFC_CK = ceil(T_RFC_PS / CLK_PERIOD_PS) clocks (16) after a refresh.
- R7: The OCD-default write is issued at the later of two times: MRD_CK after the normal-operation mode write, or OCD_GAP_CK clocks (200) after the second precharge-all.
- R8: ready_o rises MRD_CK clocks after the OCD-exit write. It then stays high, with NOP and cke_o high, until a new start.
- R9: A start pulse while the sequence is running has no effect on the command schedule.
- R10: A start pulse while ready_o is high clears ready_o and cke_o on the sampling edge and runs the whole sequence again.
- R11: After reset, cke_o, odt_o and ready_o are 0 and NOP is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch the initialization program |
| cke_o | output | 1 | Memory clock enable |
| odt_o | output | 1 | On-die termination enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | 3 | Bank address / mode register select |
| addr_o | output | 14 | Address / mode word |
| ready_o | output | 1 | Initialization complete |

## Verification
The hardest situations to reach are the two start pulses that arrive outside idle. One comes during the 25000-clock settling window and another in the middle of the refresh burst, and both must leave the schedule untouched. A further pulse arrives after ready, and it must restart the whole program from clock enable low. The bench places start pulses at these exact cycles and runs a scoreboard that holds the absolute issue cycle and the mode word of every expected command. Any shift or extra command is therefore reported. The OCD-default timing is reached with the default parameters, where the 200-clock window after the second precharge-all, not the mode write spacing, sets the issue cycle.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_STABLE, S_CKE, S_PALL1, S_EMRS2, S_EMRS3, S_EMRS1_DLL,
    S_MRS_RST, S_PALL2, S_REF, S_MRS_RUN, S_OCD_DFLT, S_OCD_EXIT, S_READY
  } state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_NOP = 4'b0111;
  localparam cmd_t CMD_PRE = 4'b0010;
  localparam cmd_t CMD_MRS = 4'b0000;
  localparam cmd_t CMD_REF = 4'b0001;

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr2_init_cmd_enc.sv
module ddr2_init_cmd_enc
  import ddr2_init_pkg::*;
#(
  parameter int BL      = 4,
  parameter int BT      = 0,
  parameter int CL      = 5,
  parameter int WR      = 4,
  parameter int AL      = 0,
  parameter int PD_SLOW = 0
) (
  input  state_e      state_i,
  output cmd_t        cmd_o,
  output logic [2:0]  ba_o,
  output logic [13:0] addr_o
);
  localparam logic [2:0] BL_CODE = (BL == 8) ? 3'd3 : 3'd2;

  function automatic logic [13:0] main_word(logic dll_rst);
    return {1'b0, 1'(PD_SLOW), 3'(WR - 1), dll_rst, 1'b0, 3'(CL), 1'(BT), BL_CODE};
  endfunction

  function automatic logic [13:0] ext1_word(logic [2:0] ocd);
    return {4'b0, ocd, 1'b0, 3'(AL), 3'b0};
  endfunction

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = 3'd0;
    addr_o = '0;
    unique case (state_i)
      S_PALL1, S_PALL2: begin cmd_o = CMD_PRE; addr_o[10] = 1'b1; end
      S_EMRS2:     begin cmd_o = CMD_MRS; ba_o = 3'd2; end
      S_EMRS3:     begin cmd_o = CMD_MRS; ba_o = 3'd3; end
      S_EMRS1_DLL: begin cmd_o = CMD_MRS; ba_o = 3'd1; addr_o = ext1_word(3'b000); end
      S_MRS_RST:   begin cmd_o = CMD_MRS; addr_o = main_word(1'b1); end
      S_REF:       cmd_o = CMD_REF;
      S_MRS_RUN:   begin cmd_o = CMD_MRS; addr_o = main_word(1'b0); end
      S_OCD_DFLT:  begin cmd_o = CMD_MRS; ba_o = 3'd1; addr_o = ext1_word(3'b111); end
      S_OCD_EXIT:  begin cmd_o = CMD_MRS; ba_o = 3'd1; addr_o = ext1_word(3'b000); end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 8000,
  parameter int T_STABLE_PS   = 200_000_000,
  parameter int T_CKE_PS      = 400_000,
  parameter int T_RP_PS       = 12_500,
  parameter int T_RFC_PS      = 127_500,
  parameter int MRD_CK        = 2,
  parameter int OCD_GAP_CK    = 200,
  parameter int N_REF         = 2,
  parameter int BL            = 4,
  parameter int BT            = 0,
  parameter int CL            = 5,
  parameter int WR            = 4,
  parameter int AL            = 0,
  parameter int PD_SLOW       = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output logic        cke_o,
  output logic        odt_o,
  output logic        cs_no,
  output logic        ras_no,
  output logic        cas_no,
  output logic        we_no,
  output logic [2:0]  ba_o,
  output logic [13:0] addr_o,
  output logic        ready_o
);
  localparam int STABLE_CK = (T_STABLE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int CKE_CK    = (T_CKE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int RP_CK     = (T_RP_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int RFC_CK    = (T_RFC_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  // spacing after the normal mode write that also meets the OCD window
  localparam int OCD_REST  = OCD_GAP_CK - RP_CK - N_REF * RFC_CK;
  localparam int RUN_CK    = (OCD_REST > MRD_CK) ? OCD_REST : MRD_CK;
  localparam int TW        = $clog2(STABLE_CK + 1);
  localparam int RCW       = (N_REF > 1) ? $clog2(N_REF) : 1;

  state_e      state_q, nxt_state;
  cmd_t        cmd_q, enc_cmd;
  logic [2:0]  ba_q, enc_ba;
  logic [13:0] addr_q, enc_addr;
  logic        cke_q, ready_q, tmr_zero, busy, start_go, adv, tmr_load;
  logic [TW-1:0]  tmr_val;
  logic [RCW-1:0] ref_cnt_q;

  function automatic logic [TW-1:0] wait_m1(state_e s);
    case (s)
      S_STABLE:                     return TW'(STABLE_CK - 1);
      S_CKE:                        return TW'(CKE_CK - 1);
      S_PALL1, S_PALL2:             return TW'(RP_CK - 1);
      S_REF:                        return TW'(RFC_CK - 1);
      S_MRS_RUN:                    return TW'(RUN_CK - 1);
      S_READY, S_IDLE:              return '0;
      default:                      return TW'(MRD_CK - 1);
    endcase
  endfunction

  assign busy     = (state_q != S_IDLE) && (state_q != S_READY);
  assign start_go = !busy && start_i;
  assign adv      = busy && tmr_zero;
  assign tmr_load = start_go || adv;
  assign tmr_val  = start_go ? TW'(STABLE_CK - 1) : wait_m1(nxt_state);

  always_comb begin
    nxt_state = state_q;
    unique case (state_q)
      S_STABLE:    nxt_state = S_CKE;
      S_CKE:       nxt_state = S_PALL1;
      S_PALL1:     nxt_state = S_EMRS2;
      S_EMRS2:     nxt_state = S_EMRS3;
      S_EMRS3:     nxt_state = S_EMRS1_DLL;
      S_EMRS1_DLL: nxt_state = S_MRS_RST;
      S_MRS_RST:   nxt_state = S_PALL2;
      S_PALL2:     nxt_state = S_REF;
      S_REF:       nxt_state = (ref_cnt_q == RCW'(N_REF - 1)) ? S_MRS_RUN : S_REF;
      S_MRS_RUN:   nxt_state = S_OCD_DFLT;
      S_OCD_DFLT:  nxt_state = S_OCD_EXIT;
      S_OCD_EXIT:  nxt_state = S_READY;
      default:     nxt_state = state_q;
    endcase
  end

  ddr2_init_timer #(.W(TW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  ddr2_init_cmd_enc #(
    .BL(BL), .BT(BT), .CL(CL), .WR(WR), .AL(AL), .PD_SLOW(PD_SLOW)
  ) i_enc (
    .state_i (nxt_state),
    .cmd_o   (enc_cmd),
    .ba_o    (enc_ba),
    .addr_o  (enc_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      cmd_q     <= CMD_NOP;
      ba_q      <= '0;
      addr_q    <= '0;
      cke_q     <= 1'b0;
      ready_q   <= 1'b0;
      ref_cnt_q <= '0;
    end else begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      if (start_go) begin
        state_q <= S_STABLE;
        cke_q   <= 1'b0;
        ready_q <= 1'b0;
      end else if (adv) begin
        state_q <= nxt_state;
        cmd_q   <= enc_cmd;
        ba_q    <= enc_ba;
        addr_q  <= enc_addr;
        if (nxt_state == S_CKE)   cke_q   <= 1'b1;
        if (nxt_state == S_READY) ready_q <= 1'b1;
        if (nxt_state == S_REF)
          ref_cnt_q <= (state_q == S_REF) ? ref_cnt_q + 1'b1 : '0;
      end
    end
  end

  assign {cs_no, ras_no, cas_no, we_no} = cmd_q;
  assign ba_o    = ba_q;
  assign addr_o  = addr_q;
  assign cke_o   = cke_q;
  assign odt_o   = 1'b0;
  assign ready_o = ready_q;

  // ---- assertion support: spacing observed at the ports ----
  localparam int AW = 16;
  localparam logic [AW-1:0] MRD_W = AW'(MRD_CK);
  localparam logic [AW-1:0] RFC_W = AW'(RFC_CK);
  localparam logic [AW-1:0] OCD_W = AW'(OCD_GAP_CK);

  logic          cmd_issue, last_mode_q, last_ref_q;
  logic [AW-1:0] gap_q, since_pre_q;

  assign cmd_issue = ({cs_no, ras_no, cas_no, we_no} != 4'b0111);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q       <= '0;
      since_pre_q <= '0;
      last_mode_q <= 1'b0;
      last_ref_q  <= 1'b0;
    end else begin
      if (cmd_issue) begin
        gap_q       <= AW'(1);
        last_mode_q <= ({cs_no, ras_no, cas_no, we_no} == 4'b0000);
        last_ref_q  <= ({cs_no, ras_no, cas_no, we_no} == 4'b0001);
      end else if (gap_q != '1) gap_q <= gap_q + 1'b1;
      if (cmd_issue && {cs_no, ras_no, cas_no, we_no} == 4'b0010) since_pre_q <= AW'(1);
      else if (since_pre_q != '1) since_pre_q <= since_pre_q + 1'b1;
    end
  end

  AST_STABLE_CKE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_STABLE |-> !cke_o && !cmd_issue);  // R1
  AST_CMD_THEN_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_issue |=> !cmd_issue);  // R2
  AST_MRD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_issue && last_mode_q |-> gap_q >= MRD_W);  // R6
  AST_RFC_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_issue && last_ref_q |-> gap_q >= RFC_W);  // R6
  AST_OCD_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_issue && ba_o == 3'd1 && addr_o[9:7] == 3'b111 |-> since_pre_q >= OCD_W);  // R7
  AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !start_i |=> ready_o);  // R8
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !cmd_issue && cke_o);  // R8
endmodule

// File: tb/test_ddr2_init_seq.sv
module test_ddr2_init_seq;
  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic cke_o, odt_o, cs_no, ras_no, cas_no, we_no, ready_o;
  logic [2:0]  ba_o;
  logic [13:0] addr_o;

  ddr2_init_seq i_ddr2_init_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cke_o(cke_o), .odt_o(odt_o),
    .cs_no(cs_no), .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no),
    .ba_o(ba_o), .addr_o(addr_o), .ready_o(ready_o)
  );

  always #4 clk = ~clk;  // 125 MHz

  // expected clock counts from the requirements at the default parameters
  localparam int ST = 25000, CKC = 50, RP = 2, MRD = 2, RFC = 16, GAP = 200, NREF = 2;
  localparam int CL = 5, WR = 4, AL = 0;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0]  cmd;
    logic [2:0]  ba;
    logic [13:0] addr;
    int          at;
    string       tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [13:0] main_word(bit dll);
    return 14'(((WR - 1) << 9) | (int'(dll) << 8) | (CL << 4) | 2);
  endfunction

  task automatic push(logic [3:0] c, logic [2:0] b, logic [13:0] a, int at, string tag);
    exp_t e;
    e.cmd = c; e.ba = b; e.addr = a; e.at = at; e.tag = tag;
    q.push_back(e);
  endtask

  // returns the cycle at which ready must rise
  task automatic push_seq(int t0, output int rdy);
    int t, tp2, tm;
    t = t0 + ST + CKC;
    push(4'b0010, 3'd0, 14'h0400, t, "R5 first precharge-all");  t += RP;
    push(4'b0000, 3'd2, 14'h0,    t, "R3 ext2 write");           t += MRD;
    push(4'b0000, 3'd3, 14'h0,    t, "R3 ext3 write");           t += MRD;
    push(4'b0000, 3'd1, 14'(AL << 3), t, "R3 DLL enable");       t += MRD;
    push(4'b0000, 3'd0, main_word(1), t, "R4 DLL reset word");   t += MRD;
    tp2 = t;
    push(4'b0010, 3'd0, 14'h0400, t, "R6 second precharge-all"); t += RP;
    for (int i = 0; i < NREF; i++) begin
      push(4'b0001, 3'd0, 14'h0, t, "R6 refresh"); t += RFC;
    end
    tm = t;
    push(4'b0000, 3'd0, main_word(0), t, "R4 normal word");
    t = (tm + MRD > tp2 + GAP) ? tm + MRD : tp2 + GAP;
    push(4'b0000, 3'd1, 14'h0380, t, "R7 OCD default");          t += MRD;
    push(4'b0000, 3'd1, 14'h0000, t, "R3 OCD exit");
    rdy = t + MRD;
  endtask

  // monitor: scoreboard compare at every command, ODT check every cycle
  always @(negedge clk) begin
    logic [3:0] c;
    exp_t e;
    if (rst_ni && !done) begin
      c = {cs_no, ras_no, cas_no, we_no};
      if (odt_o !== 1'b0) chk(0, "R1", "odt low", int'(odt_o), 0);
      if (c != 4'b0111) begin
        if (q.size() == 0) chk(0, "R2", "unexpected command", int'(c), 7);
        else begin
          e = q.pop_front();
          chk(c == e.cmd, e.tag, "command code R2", int'(c), int'(e.cmd));
          chk(ba_o == e.ba, e.tag, "bank", int'(ba_o), int'(e.ba));
          chk(addr_o == e.addr, e.tag, "address", int'(addr_o), int'(e.addr));
          chk(cyc == e.at, e.tag, "issue cycle", cyc, e.at);
        end
      end else if (ba_o != 3'd0 || addr_o != 14'd0) begin
        chk(0, "R2", "NOP with nonzero ba/addr", int'({ba_o, addr_o}), 0);
      end
    end
  end

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pulse(output int t0);
    @(negedge clk);
    start_i = 1'b1;
    t0 = cyc + 1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic finish_test();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_test();
  end

  initial begin
    int t0, t1, tx, rdy;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cke_o == 1'b0, "R11", "cke after reset", int'(cke_o), 0);
    chk(ready_o == 1'b0, "R11", "ready after reset", int'(ready_o), 0);
    chk({cs_no, ras_no, cas_no, we_no} == 4'b0111, "R11", "NOP after reset",
        int'({cs_no, ras_no, cas_no, we_no}), 7);
    repeat (10) @(negedge clk);

    // first run
    pulse(t0);
    push_seq(t0, rdy);
    wait_until(t0 + 100);
    pulse(tx);  // R9: ignored during settling window
    wait_until(t0 + ST - 1);
    chk(cke_o == 1'b0, "R1", "cke before settle end", int'(cke_o), 0);
    @(negedge clk);
    chk(cke_o == 1'b1, "R1", "cke at settle end", int'(cke_o), 1);
    wait_until(t0 + ST + CKC + RP + 4 * MRD + RP + 5);
    pulse(tx);  // R9: ignored during refresh burst
    wait_until(rdy - 1);
    chk(ready_o == 1'b0, "R8", "ready before final wait", int'(ready_o), 0);
    @(negedge clk);
    chk(ready_o == 1'b1, "R8", "ready rise", int'(ready_o), 1);
    repeat (20) @(negedge clk);
    chk(ready_o == 1'b1 && cke_o == 1'b1, "R8", "ready and cke held",
        int'({ready_o, cke_o}), 3);
    chk(q.size() == 0, "R9", "schedule fully consumed after stray starts", q.size(), 0);

    // restart from ready
    pulse(t1);
    push_seq(t1, rdy);
    chk(ready_o == 1'b0, "R10", "ready cleared on restart", int'(ready_o), 0);
    chk(cke_o == 1'b0, "R10", "cke cleared on restart", int'(cke_o), 0);
    wait_until(t1 + ST);
    chk(cke_o == 1'b1, "R10", "cke rise in second run", int'(cke_o), 1);
    wait_until(rdy);
    chk(ready_o == 1'b1, "R10", "ready after second run", int'(ready_o), 1);
    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R3", "all expected commands seen", q.size(), 0);
    finish_test();
  end
endmodule